// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block drives the column side of a DRAM device model during burst reads. While a row is open, the controller toggles a column strobe. The first rising edge of that strobe only captures the column address from the external address bus and produces no data. Every later rising edge emits one data word: the data-valid flag goes high for one cycle, and the column address output names the column that word came from. After that first capture, the address comes from an internal counter and no longer from the bus.

The burst length is selected as 1, 2, 4 or 8 columns. The choice is captured together with the start address. The counter wraps inside the aligned block of that length, so the column bits above the block never change during a burst. Once the programmed number of words has been emitted, further strobe edges are ignored. If the controller stops toggling the strobe early, data stops at once. Closing the row clears everything, and the next strobe edge after the row reopens captures a new start address.

Both outputs are registered. The following strobe edge can therefore arrive while the previous word is still being consumed. The storage array and row decoding lie outside this block.

Top module: `burst_col_counter`

## Requirements
- R1: During and right after reset, `colAddr` is 0 and `dataValid` is 0.
- R2: The first rising edge of `colStrobe` seen while `rowActive` is high captures `colAddrIn`. In the next cycle `colAddr` equals that address and `dataValid` stays 0.
- R3: Each later rising strobe edge, up to the burst length, makes `dataValid` high in the cycle after the edge. `colAddr` then shows the word's column, taken from the internal counter. Changes on `colAddrIn` after the capture have no effect.
- R4: `dataValid` lasts one cycle per edge. While the strobe is held high or held low there is no rising edge, so `dataValid` is 0 and `colAddr` holds its value.
- R5: `burstSel` encodes the burst length: 0 selects 1, 1 selects 2, 2 selects 4, 3 selects 8. The value present at the capture edge applies to the whole burst, and later changes are ignored.
- R6: With start address B and length L, the word for beat k (k = 0..L-1) is `(B & ~(L-1)) | ((B + k) & (L-1))`.
- R7: After L words, further strobe edges leave `dataValid` at 0 and `colAddr` at the last word's column.
- R8: When `rowActive` is low at a clock edge, `colAddr` and `dataValid` are 0 in the next cycle. The first strobe edge after the row reopens is again a capture.
- R9: Strobe edges while `rowActive` is low emit nothing and capture nothing.
- R10: Within one burst, the bits of `colAddr` above the low three are never changed by a data step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rowActive | input | 1 | High while a row is open |
| colStrobe | input | 1 | Column strobe; its rising edges (sampled on clk) are acted on |
| colAddrIn | input | COL_W | External column address, used only at the capture edge |
| burstSel | input | 2 | Burst length code (0:1, 1:2, 2:4, 3:8) |
| colAddr | output | COL_W | Column of the captured start or of the word being emitted |
| dataValid | output | 1 | One-cycle flag that a data word is on the output |

## Verification
A strobe edge is recognised at the clock edge where the strobe is sampled high after having been low. Both outputs are registered at that same edge, so every result is due exactly one clock after the strobe rises. A row close likewise shows on the outputs one clock after `rowActive` is sampled low. The bench drives inputs on the falling edge and checks at the next falling edge, which lies half a period after the edge that updates the outputs. It also makes a second check one cycle later, with the strobe low, to confirm that the pulse has ended and the address is held. All four lengths are swept over start addresses that cover every offset inside the block and some high addresses. Each burst runs two edges past its length and changes the bus address and the length code during the burst.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  // Offset width inside the largest (8-column) burst block
  localparam int OFF_W = 3;
  localparam int CNT_W = OFF_W + 1;

  typedef enum logic [1:0] {
    BL1 = 2'd0,
    BL2 = 2'd1,
    BL4 = 2'd2,
    BL8 = 2'd3
  } burstLen_e;

  typedef struct packed {
    logic clear;  // row closed: drop all state
    logic load;   // capture external column address
    logic step;   // emit one word and advance the pointer
  } colStrobes_t;
endpackage

// File: rtl/bcc_ctrl.sv
module bcc_ctrl
  import bcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rowActive,
  input  logic              colStrobe,
  input  logic [1:0]        burstSel,
  output colStrobes_t       strobes,
  output logic [OFF_W-1:0]  wrapMask
);
  logic             strobePrev;
  logic             loaded;
  logic [CNT_W-1:0] beatsDone;
  logic [CNT_W-1:0] burstLen;
  logic [CNT_W-1:0] selLen;
  logic             riseSeen;

  assign selLen   = CNT_W'(1) << burstSel;
  assign riseSeen = colStrobe & ~strobePrev;

  always_comb begin
    strobes.clear = ~rowActive;
    strobes.load  = rowActive & riseSeen & ~loaded;
    strobes.step  = rowActive & riseSeen & loaded & (beatsDone < burstLen);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobePrev <= 1'b0;
      loaded     <= 1'b0;
      beatsDone  <= '0;
      burstLen   <= '0;
      wrapMask   <= '0;
    end else begin
      strobePrev <= colStrobe;
      if (strobes.clear) begin
        loaded    <= 1'b0;
        beatsDone <= '0;
        burstLen  <= '0;
        wrapMask  <= '0;
      end else if (strobes.load) begin
        loaded    <= 1'b1;
        beatsDone <= '0;
        burstLen  <= selLen;
        wrapMask  <= OFF_W'(selLen - CNT_W'(1));
      end else if (strobes.step) begin
        beatsDone <= beatsDone + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/bcc_datapath.sv
module bcc_datapath
  import bcc_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  colStrobes_t       strobes,
  input  logic [OFF_W-1:0]  wrapMask,
  input  logic [COL_W-1:0]  colAddrIn,
  output logic [COL_W-1:0]  colAddr,
  output logic              dataValid
);
  logic [COL_W-1:0] colPtr;
  logic [COL_W-1:0] fullMask;
  logic [COL_W-1:0] ptrNext;

  assign fullMask = COL_W'(wrapMask);
  assign ptrNext  = (colPtr & ~fullMask) | ((colPtr + COL_W'(1)) & fullMask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      colPtr    <= '0;
      colAddr   <= '0;
      dataValid <= 1'b0;
    end else if (strobes.clear) begin
      colPtr    <= '0;
      colAddr   <= '0;
      dataValid <= 1'b0;
    end else if (strobes.load) begin
      colPtr    <= colAddrIn;
      colAddr   <= colAddrIn;
      dataValid <= 1'b0;
    end else if (strobes.step) begin
      colPtr    <= ptrNext;
      colAddr   <= colPtr;
      dataValid <= 1'b1;
    end else begin
      dataValid <= 1'b0;
    end
  end
endmodule

// File: rtl/burst_col_counter.sv
module burst_col_counter
  import bcc_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rowActive,
  input  logic             colStrobe,
  input  logic [COL_W-1:0] colAddrIn,
  input  logic [1:0]       burstSel,
  output logic [COL_W-1:0] colAddr,
  output logic             dataValid
);
  colStrobes_t      strobes;
  logic [OFF_W-1:0] wrapMask;

  bcc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .rowActive (rowActive),
    .colStrobe (colStrobe),
    .burstSel  (burstSel),
    .strobes   (strobes),
    .wrapMask  (wrapMask)
  );

  bcc_datapath #(.COL_W(COL_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .wrapMask  (wrapMask),
    .colAddrIn (colAddrIn),
    .colAddr   (colAddr),
    .dataValid (dataValid)
  );
endmodule

// File: rtl/bcc_checker.sv
module bcc_checker
  import bcc_pkg::*;
#(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rowActive,
  input logic             colStrobe,
  input logic [COL_W-1:0] colAddr,
  input logic             dataValid
);
  logic [CNT_W:0] pulseCount;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulseCount <= '0;
    else if (!rowActive) pulseCount <= '0;
    else if (dataValid && pulseCount != '1) pulseCount <= pulseCount + 1'b1;
  end

  AST_VALID_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    dataValid |-> ($past(colStrobe) && !$past(colStrobe, 2) && $past(rowActive))); // R3

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dataValid |=> !dataValid); // R4

  AST_ROW_CLOSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !rowActive |=> (!dataValid && colAddr == '0)); // R8

  AST_BLOCK_BITS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    dataValid |-> (colAddr[COL_W-1:OFF_W] == $past(colAddr[COL_W-1:OFF_W]))); // R10

  AST_BURST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    dataValid |-> (pulseCount < (CNT_W+1)'(8))); // R7
endmodule

bind burst_col_counter bcc_checker #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rowActive (rowActive),
  .colStrobe (colStrobe),
  .colAddr   (colAddr),
  .dataValid (dataValid)
);

// File: tb/burst_col_counter_test.sv
`timescale 1ns/1ps
module burst_col_counter_test;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rowActive = 1'b0;
  logic             colStrobe = 1'b0;
  logic [COL_W-1:0] colAddrIn = '0;
  logic [1:0]       burstSel = '0;
  logic [COL_W-1:0] colAddr;
  logic             dataValid;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  burst_col_counter #(.COL_W(COL_W)) uut (
    .clk(clk), .rst_n(rst_n), .rowActive(rowActive), .colStrobe(colStrobe),
    .colAddrIn(colAddrIn), .burstSel(burstSel),
    .colAddr(colAddr), .dataValid(dataValid)
  );

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic nextCycle();
    @(negedge clk);
  endtask

  task automatic riseStrobe();
    colStrobe = 1'b1;
    nextCycle();
  endtask

  task automatic fallStrobe(string req, int heldAddr);
    colStrobe = 1'b0;
    nextCycle();
    check({req, " valid after strobe low"}, int'(dataValid), 0);   // R4
    check({req, " addr held"}, int'(colAddr), heldAddr);           // R4
  endtask

  task automatic closeRow();
    rowActive = 1'b0;
    nextCycle();
    check("R8 addr cleared", int'(colAddr), 0);
    check("R8 valid cleared", int'(dataValid), 0);
  endtask

  task automatic runBurst(int sel, int base);
    int len = 1 << sel;
    int lastWord = 0;
    burstSel  = 2'(sel);
    colAddrIn = COL_W'(base);
    closeRow();
    rowActive = 1'b1;
    nextCycle();
    riseStrobe();
    check("R2 captured addr", int'(colAddr), base);
    check("R2 no data on capture", int'(dataValid), 0);
    fallStrobe("R2", base);
    colAddrIn = ~COL_W'(base);   // R3: bus ignored after capture
    burstSel  = 2'(sel ^ 3);     // R5: length fixed at capture
    for (int k = 0; k < len + 2; k++) begin
      riseStrobe();
      if (k < len) begin
        int expAddr = (base & ~(len - 1)) | ((base + k) & (len - 1));
        lastWord = expAddr;
        check("R3 data valid on step", int'(dataValid), 1);
        check("R6/R10 wrapped word column", int'(colAddr), expAddr);
      end else begin
        check("R7 valid after burst end", int'(dataValid), 0);
        check("R7 addr frozen", int'(colAddr), lastWord);
      end
      fallStrobe("R4", lastWord);
    end
    // R4: strobe held high then low without a new edge gives nothing
    colStrobe = 1'b1;
    nextCycle();
    nextCycle();
    nextCycle();
    check("R4 held strobe no data", int'(dataValid), 0);
    colStrobe = 1'b0;
  endtask

  initial begin
    nextCycle();
    check("R1 reset addr", int'(colAddr), 0);
    check("R1 reset valid", int'(dataValid), 0);
    rst_n = 1'b1;
    nextCycle();
    check("R1 after reset valid", int'(dataValid), 0);

    // R9: edges with row closed do nothing
    riseStrobe();
    check("R9 no capture while closed", int'(colAddr), 0);
    check("R9 no data while closed", int'(dataValid), 0);
    colStrobe = 1'b0;
    nextCycle();

    // Sweep of all lengths over every block offset plus high addresses
    for (int sel = 0; sel < 4; sel++) begin
      for (int off = 0; off < 8; off++) runBurst(sel, 16 + off);
      runBurst(sel, 1023);
      runBurst(sel, 517);
    end

    // R8: close mid-burst, reopen, first edge captures again
    burstSel = 2'(3);
    colAddrIn = COL_W'(42);
    closeRow();
    rowActive = 1'b1;
    nextCycle();
    riseStrobe();
    fallStrobe("R2", 42);
    riseStrobe();
    check("R3 first word", int'(colAddr), 42);
    fallStrobe("R4", 42);
    closeRow();
    colAddrIn = COL_W'(300);
    rowActive = 1'b1;
    nextCycle();
    riseStrobe();
    check("R8 reopen recaptures", int'(colAddr), 300);
    check("R8 reopen no data", int'(dataValid), 0);
    fallStrobe("R8", 300);
    riseStrobe();
    check("R8 new burst first word", int'(colAddr), 300);
    check("R8 new burst valid", int'(dataValid), 1);
    colStrobe = 1'b0;
    nextCycle();

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule